// File: doc/BRIEF.md
# Banked Memory Read Router

This block sits on the read side of an 8-bit microcontroller system with a 24-bit address space. Each read presents a 24-bit address, a flag telling an opcode fetch from a data access, and a read strobe. The router picks one target from the address: internal ROM, an optional cartridge, main RAM, sprite-fragment RAM, two palette RAM halves, a small bank of segment registers, or a built-in test-pattern responder. It returns the selected byte one clock later, marked by a valid output.

The address splits into a bank (bits 23:16) and a 16-bit offset. High banks and the upper half of every low bank are ROM space. The cartridge serves ROM space when one is inserted and the address falls under a configurable limit; otherwise internal ROM answers, mirrored by its power-of-two size. The lower half of a low bank is a 15-bit local bus holding the RAMs, the registers and the pattern responder. The responder returns nibble-swapped offset bytes with per-quadrant inversion, or one of three byte latches written through a dedicated port.

For bring-up and test, every storage target can be preloaded through a byte write port.

Top module: `bank_read_router`

## Requirements
- R1: Read data and `rd_valid_o` appear exactly one clock after a cycle with `rd_valid_i` high; in any cycle where `rd_valid_o` is low, `rd_data_o` is 0x00. After reset `rd_valid_o` is low.
- R2: Any read with address bits 23:16 at 0x80 or above goes to ROM space, whether it is an opcode fetch or a data read; the fetch flag never changes which target is selected.
- R3: With bank below 0x80, an offset (bits 15:0) of 0x8000 or above goes to ROM space; below 0x8000 it goes to the local bus using only bits 14:0, so the bank value has no effect there.
- R4: Internal ROM is indexed by the address ANDed with 2^ROM_AW−1, so the image mirrors across ROM space (ROM_AW defaults to 11).
- R5: ROM space reads come from the cartridge, indexed by the low CART_AW address bits, only when `cart_present_i` is high and (address AND 0x7FFFFF) is below CART_LIMIT (default 0x400000); every other ROM-space read comes from internal ROM.
- R6: Local-bus map: 0x0000–0x3FFF main RAM (indexed by the low MAIN_AW bits, default 12, so it mirrors), 0x6000–0x67FF sprite-fragment RAM, 0x6800–0x68FF palette half A, 0x6900–0x69FF palette half B, 0x6A00–0x6A1F segment registers.
- R7: Local-bus addresses outside every mapped range (for example 0x5000–0x5FFF, 0x6A20–0x7FFF) read 0x00.
- R8: At local-bus 0x4000–0x43FF, with b the low address byte, the result is b with nibbles swapped; in 0x41xx the new upper nibble is inverted, in 0x42xx the new lower nibble is inverted, in 0x43xx both are inverted, in 0x40xx neither.
- R9: Local-bus 0x4400–0x47FF, 0x4800–0x4BFF and 0x4C00–0x4FFF return latches 1, 2 and 3. A write with `lat_we_i` high and `lat_sel_i` = 1, 2 or 3 loads that latch; `lat_sel_i` = 0 writes nothing. Latches reset to 0x00.
- R10: Preload writes (`ld_we_i`) go to the target coded by `ld_tgt_i`: 0 ROM, 1 cartridge, 2 main RAM, 3 sprite RAM, 4 palette A, 5 palette B, 6 segment registers, 7 none; the index is the low bits of `ld_addr_i` matching each target's depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid_i | input | 1 | Read strobe |
| rd_addr_i | input | 24 | Read address |
| rd_fetch_i | input | 1 | High for an opcode fetch |
| cart_present_i | input | 1 | Cartridge inserted |
| rd_valid_o | output | 1 | Read data valid, one clock after the strobe |
| rd_data_o | output | 8 | Read data byte |
| lat_we_i | input | 1 | Responder latch write strobe |
| lat_sel_i | input | 2 | Latch select (responder offset bits 11:10) |
| lat_data_i | input | 8 | Latch write data |
| ld_we_i | input | 1 | Preload write strobe |
| ld_tgt_i | input | 3 | Preload target code |
| ld_addr_i | input | 12 | Preload index |
| ld_data_i | input | 8 | Preload data |

## Verification
The bench probes the cartridge limit from both sides, using an address in a high bank whose masked value lands just under the limit and a low-bank address just over it; a wrong mask or comparison would serve the wrong image. It checks that ROM and main RAM mirror and that the bank is ignored on the local bus, which a decoder using too many bits would break by reading unwritten or wrong locations. It reads all four responder quadrants and the edges of each latch range, and checks that a latch write with select 0 changes nothing, so a swapped inversion rule or an off-by-one range boundary shows up as a wrong byte. Unmapped holes next to the segment registers and palette halves are read after neighbouring locations were loaded, so any aliasing returns nonzero data.

// File: rtl/brr_pkg.sv
package brr_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 8;
  localparam int SPR_AW = 11;
  localparam int PAL_AW = 8;
  localparam int SEG_AW = 5;
  localparam int OFF_W  = 12;

  typedef enum logic [3:0] {
    T_ROM, T_CART, T_MAIN, T_SPR, T_PALA, T_PALB, T_SEG, T_PAT, T_NONE
  } tgt_e;

  // preload target codes
  localparam logic [2:0] LD_ROM  = 3'd0;
  localparam logic [2:0] LD_CART = 3'd1;
  localparam logic [2:0] LD_MAIN = 3'd2;
  localparam logic [2:0] LD_SPR  = 3'd3;
  localparam logic [2:0] LD_PALA = 3'd4;
  localparam logic [2:0] LD_PALB = 3'd5;
  localparam logic [2:0] LD_SEG  = 3'd6;
  localparam int NUM_LD = 7;
endpackage

// File: rtl/brr_sram.sv
module brr_sram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/brr_decode.sv
module brr_decode
  import brr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CART_LIMIT = 24'h400000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              fetch,
  input  logic              cart_present,
  output tgt_e              tgt
);
  logic        high_bank;
  logic        rom_space;
  logic        cart_hit;
  logic [14:0] lo;

  always_comb begin
    high_bank = addr[23];
    // opcode fetches in high banks see ROM; data reads there do too
    rom_space = high_bank | (fetch & high_bank) | addr[15];
    cart_hit  = cart_present && ({1'b0, addr[22:0]} < CART_LIMIT);
    lo        = addr[14:0];
    if (rom_space) begin
      tgt = cart_hit ? T_CART : T_ROM;
    end else if (lo < 15'h4000) begin
      tgt = T_MAIN;
    end else if (lo[14:12] == 3'b100) begin
      tgt = T_PAT;
    end else if (lo[14:11] == 4'b1100) begin
      tgt = T_SPR;
    end else if (lo[14:8] == 7'h68) begin
      tgt = T_PALA;
    end else if (lo[14:8] == 7'h69) begin
      tgt = T_PALB;
    end else if (lo[14:5] == 10'h350) begin
      tgt = T_SEG;
    end else begin
      tgt = T_NONE;
    end
  end
endmodule

// File: rtl/brr_pattern.sv
module brr_pattern
  import brr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lat_we,
  input  logic [1:0]        lat_sel,
  input  logic [DATA_W-1:0] lat_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NLAT = 3;
  logic [DATA_W-1:0] lat_q [NLAT];
  logic [DATA_W-1:0] pat;
  logic [3:0]        lo_n, hi_n;

  for (genvar g = 0; g < NLAT; g++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst) lat_q[g] <= '0;
      else if (lat_we && (lat_sel == 2'(g + 1))) lat_q[g] <= lat_data;
    end
  end

  always_comb begin
    lo_n = rd_off[3:0];
    hi_n = rd_off[7:4];
    case (rd_off[11:10])
      2'd0: begin
        case (rd_off[9:8])
          2'd0:    pat = {lo_n, hi_n};
          2'd1:    pat = {~lo_n, hi_n};
          2'd2:    pat = {lo_n, ~hi_n};
          default: pat = {~lo_n, ~hi_n};
        endcase
      end
      2'd1:    pat = lat_q[0];
      2'd2:    pat = lat_q[1];
      default: pat = lat_q[2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= pat;
  end
endmodule

// File: rtl/bank_read_router.sv
module bank_read_router
  import brr_pkg::*;
#(
  parameter int ROM_AW  = 11,
  parameter int CART_AW = 11,
  parameter int MAIN_AW = 12,
  parameter logic [ADDR_W-1:0] CART_LIMIT = 24'h400000,
  localparam int LD_AW_A = (ROM_AW > CART_AW) ? ROM_AW : CART_AW,
  localparam int LD_AW_B = (MAIN_AW > SPR_AW) ? MAIN_AW : SPR_AW,
  localparam int LD_AW   = (LD_AW_A > LD_AW_B) ? LD_AW_A : LD_AW_B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              rd_fetch_i,
  input  logic              cart_present_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              lat_we_i,
  input  logic [1:0]        lat_sel_i,
  input  logic [DATA_W-1:0] lat_data_i,
  input  logic              ld_we_i,
  input  logic [2:0]        ld_tgt_i,
  input  logic [LD_AW-1:0]  ld_addr_i,
  input  logic [DATA_W-1:0] ld_data_i
);
  tgt_e              tgt_d, tgt_q;
  logic              valid_q;
  logic [NUM_LD-1:0] ld_hit;
  logic [DATA_W-1:0] rom_q, cart_q, main_q, spr_q, pala_q, palb_q, seg_q, pat_q;

  brr_decode #(.CART_LIMIT(CART_LIMIT)) u_dec (
    .addr(rd_addr_i), .fetch(rd_fetch_i), .cart_present(cart_present_i), .tgt(tgt_d)
  );

  always_comb begin
    for (int k = 0; k < NUM_LD; k++) ld_hit[k] = ld_we_i && (ld_tgt_i == 3'(k));
  end

  brr_sram #(.AW(ROM_AW)) u_rom (
    .clk(clk), .we(ld_hit[LD_ROM]), .waddr(ld_addr_i[ROM_AW-1:0]), .wdata(ld_data_i),
    .raddr(rd_addr_i[ROM_AW-1:0]), .rdata(rom_q)
  );
  brr_sram #(.AW(CART_AW)) u_cart (
    .clk(clk), .we(ld_hit[LD_CART]), .waddr(ld_addr_i[CART_AW-1:0]), .wdata(ld_data_i),
    .raddr(rd_addr_i[CART_AW-1:0]), .rdata(cart_q)
  );
  brr_sram #(.AW(MAIN_AW)) u_main (
    .clk(clk), .we(ld_hit[LD_MAIN]), .waddr(ld_addr_i[MAIN_AW-1:0]), .wdata(ld_data_i),
    .raddr(rd_addr_i[MAIN_AW-1:0]), .rdata(main_q)
  );
  brr_sram #(.AW(SPR_AW)) u_spr (
    .clk(clk), .we(ld_hit[LD_SPR]), .waddr(ld_addr_i[SPR_AW-1:0]), .wdata(ld_data_i),
    .raddr(rd_addr_i[SPR_AW-1:0]), .rdata(spr_q)
  );
  brr_sram #(.AW(PAL_AW)) u_pala (
    .clk(clk), .we(ld_hit[LD_PALA]), .waddr(ld_addr_i[PAL_AW-1:0]), .wdata(ld_data_i),
    .raddr(rd_addr_i[PAL_AW-1:0]), .rdata(pala_q)
  );
  brr_sram #(.AW(PAL_AW)) u_palb (
    .clk(clk), .we(ld_hit[LD_PALB]), .waddr(ld_addr_i[PAL_AW-1:0]), .wdata(ld_data_i),
    .raddr(rd_addr_i[PAL_AW-1:0]), .rdata(palb_q)
  );
  brr_sram #(.AW(SEG_AW)) u_seg (
    .clk(clk), .we(ld_hit[LD_SEG]), .waddr(ld_addr_i[SEG_AW-1:0]), .wdata(ld_data_i),
    .raddr(rd_addr_i[SEG_AW-1:0]), .rdata(seg_q)
  );

  brr_pattern u_pat (
    .clk(clk), .rst(rst), .lat_we(lat_we_i), .lat_sel(lat_sel_i), .lat_data(lat_data_i),
    .rd_off(rd_addr_i[OFF_W-1:0]), .rd_data(pat_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      tgt_q   <= T_NONE;
    end else begin
      valid_q <= rd_valid_i;
      tgt_q   <= tgt_d;
    end
  end

  assign rd_valid_o = valid_q;

  always_comb begin
    rd_data_o = '0;
    if (valid_q) begin
      case (tgt_q)
        T_ROM:   rd_data_o = rom_q;
        T_CART:  rd_data_o = cart_q;
        T_MAIN:  rd_data_o = main_q;
        T_SPR:   rd_data_o = spr_q;
        T_PALA:  rd_data_o = pala_q;
        T_PALB:  rd_data_o = palb_q;
        T_SEG:   rd_data_o = seg_q;
        T_PAT:   rd_data_o = pat_q;
        default: rd_data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/brr_checker.sv
module brr_checker (
  input logic        clk,
  input logic        rst,
  input logic        rd_valid_i,
  input logic [23:0] rd_addr_i,
  input logic        rd_valid_o,
  input logic [7:0]  rd_data_o
);
  // R1
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_valid_i |=> rd_valid_o);
  // R1
  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !rd_valid_i |=> !rd_valid_o);
  // R1
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_valid_o |-> rd_data_o == 8'h00);
  // R7
  a_r7_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_i && !rd_addr_i[23] && rd_addr_i[15:12] == 4'h5) |=> rd_data_o == 8'h00);
  // R8
  a_r8_plain_swap: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_i && !rd_addr_i[23] && rd_addr_i[15:8] == 8'h40)
      |=> rd_data_o == {$past(rd_addr_i[3:0]), $past(rd_addr_i[7:4])});
  // R8
  a_r8_full_invert: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_i && !rd_addr_i[23] && rd_addr_i[15:8] == 8'h43)
      |=> rd_data_o == ~{$past(rd_addr_i[3:0]), $past(rd_addr_i[7:4])});
endmodule

bind bank_read_router brr_checker u_chk (
  .clk(clk), .rst(rst), .rd_valid_i(rd_valid_i), .rd_addr_i(rd_addr_i),
  .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
);

// File: tb/bank_read_router_tb.sv
module bank_read_router_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        rd_valid_i = 1'b0;
  logic [23:0] rd_addr_i = '0;
  logic        rd_fetch_i = 1'b0;
  logic        cart_present_i = 1'b0;
  logic        rd_valid_o;
  logic [7:0]  rd_data_o;
  logic        lat_we_i = 1'b0;
  logic [1:0]  lat_sel_i = '0;
  logic [7:0]  lat_data_i = '0;
  logic        ld_we_i = 1'b0;
  logic [2:0]  ld_tgt_i = '0;
  logic [11:0] ld_addr_i = '0;
  logic [7:0]  ld_data_i = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bank_read_router u_dut (
    .clk(clk), .rst(rst), .rd_valid_i(rd_valid_i), .rd_addr_i(rd_addr_i),
    .rd_fetch_i(rd_fetch_i), .cart_present_i(cart_present_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .lat_we_i(lat_we_i), .lat_sel_i(lat_sel_i), .lat_data_i(lat_data_i),
    .ld_we_i(ld_we_i), .ld_tgt_i(ld_tgt_i), .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] tgt, input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_we_i = 1'b1; ld_tgt_i = tgt; ld_addr_i = a; ld_data_i = d;
    @(negedge clk);
    ld_we_i = 1'b0;
  endtask

  task automatic lat_wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    lat_we_i = 1'b1; lat_sel_i = sel; lat_data_i = d;
    @(negedge clk);
    lat_we_i = 1'b0;
  endtask

  // presents a read, then samples one clock later at the falling edge
  task automatic rd(input string req, input logic [23:0] a, input logic f, input logic [7:0] exp);
    @(negedge clk);
    rd_valid_i = 1'b1; rd_addr_i = a; rd_fetch_i = f;
    @(negedge clk);
    rd_valid_i = 1'b0;
    chk({req, " valid"}, {7'd0, rd_valid_o}, 8'd1);
    chk(req, rd_data_o, exp);
  endtask

  task automatic t_reset;
    chk("R1 reset valid", {7'd0, rd_valid_o}, 8'd0);
    chk("R1 reset data", rd_data_o, 8'h00);
  endtask

  task automatic t_rom;
    load(3'd0, 12'h123, 8'hA1);
    rd("R3 low bank upper half", 24'h008123, 1'b0, 8'hA1);
    rd("R2 data high bank", 24'h800123, 1'b0, 8'hA1);
    rd("R2 fetch high bank", 24'h9F0123, 1'b1, 8'hA1);
    rd("R4 ROM mirror", 24'h00F923, 1'b0, 8'hA1);
  endtask

  task automatic t_cart;
    load(3'd1, 12'h123, 8'hC3);
    cart_present_i = 1'b1;
    rd("R5 cart low address", 24'h008123, 1'b0, 8'hC3);
    rd("R5 cart just under limit", 24'hBFF923, 1'b0, 8'hC3);
    rd("R5 at limit falls back", 24'hC00123, 1'b0, 8'hA1);
    rd("R5 low bank over limit", 24'h40F923, 1'b0, 8'hA1);
    cart_present_i = 1'b0;
    rd("R5 no cart", 24'h008123, 1'b0, 8'hA1);
  endtask

  task automatic t_lowbus;
    load(3'd2, 12'h045, 8'h11);
    load(3'd3, 12'h7FF, 8'h22);
    load(3'd4, 12'h010, 8'h33);
    load(3'd5, 12'h010, 8'h44);
    load(3'd6, 12'h01F, 8'h55);
    load(3'd6, 12'h000, 8'h66);
    rd("R6 main RAM", 24'h000045, 1'b0, 8'h11);
    rd("R3 bank ignored on local bus", 24'h7F0045, 1'b0, 8'h11);
    rd("R2 fetch flag no effect", 24'h000045, 1'b1, 8'h11);
    rd("R6 main RAM mirror", 24'h001045, 1'b0, 8'h11);
    rd("R10 sprite RAM", 24'h0067FF, 1'b0, 8'h22);
    rd("R10 palette A", 24'h006810, 1'b0, 8'h33);
    rd("R10 palette B", 24'h006910, 1'b0, 8'h44);
    rd("R6 segment regs", 24'h006A1F, 1'b0, 8'h55);
    rd("R6 segment regs base", 24'h006A00, 1'b0, 8'h66);
  endtask

  task automatic t_holes;
    rd("R7 hole 5000", 24'h005000, 1'b0, 8'h00);
    rd("R7 after segments", 24'h006A20, 1'b0, 8'h00);
    rd("R7 top of local bus", 24'h007FFF, 1'b0, 8'h00);
  endtask

  task automatic t_pattern;
    rd("R8 quadrant 0", 24'h004037, 1'b0, 8'h73);
    rd("R8 quadrant 1", 24'h004137, 1'b0, 8'h83);
    rd("R8 quadrant 2", 24'h004237, 1'b0, 8'h7C);
    rd("R8 quadrant 3", 24'h004337, 1'b0, 8'h8C);
  endtask

  task automatic t_latches;
    rd("R9 latch reset", 24'h004400, 1'b0, 8'h00);
    lat_wr(2'd1, 8'h9A);
    lat_wr(2'd2, 8'hB2);
    lat_wr(2'd3, 8'hC7);
    rd("R9 latch 1 top", 24'h0047FF, 1'b0, 8'h9A);
    rd("R9 latch 2 base", 24'h004800, 1'b0, 8'hB2);
    rd("R9 latch 3", 24'h004C00, 1'b0, 8'hC7);
    lat_wr(2'd0, 8'hEE);
    rd("R9 select 0 keeps pattern", 24'h004037, 1'b0, 8'h73);
    rd("R9 select 0 keeps latch 1", 24'h004400, 1'b0, 8'h9A);
    rd("R9 select 0 keeps latch 2", 24'h004BFF, 1'b0, 8'hB2);
    rd("R9 select 0 keeps latch 3", 24'h004FFF, 1'b0, 8'hC7);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R1 valid drops", {7'd0, rd_valid_o}, 8'd0);
    chk("R1 idle data zero", rd_data_o, 8'h00);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rom();
    t_cart();
    t_lowbus();
    t_holes();
    t_pattern();
    t_latches();
    t_idle();
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule